// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the eight interrupt flags shared by a 16-bit timer and an 8-bit timer, and it produces their interrupt requests. For the 16-bit timer it detects the events itself. It compares the running count against two compare values and a capture/TOP value, it watches for the count wrapping, and it takes an external capture pulse. The 8-bit timer detects its own three events and hands them in as single-cycle pulses.

A flag is set only in system-clock cycles where the timer clock-enable `tick` is high. A flag is cleared in two ways: software writes a one to its bit, or the interrupt controller pulses the matching acknowledge line when it takes the vector. Bus writes and acknowledges act on every system clock. Each flag is combined with its bit in an enable mask and with a global enable to form a per-flag interrupt request. The flag byte can be read combinationally at any time.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset (`rst_n` low) every flag reads 0 and every `irq` bit is 0.
- R2: `rd_data` shows the current flag byte with no clock delay. Bit 7 is the 16-bit overflow flag, bit 6 is the 16-bit compare A flag and bit 5 is the 16-bit compare B flag. Bit 4 is reserved: it always reads 0 and ignores writes. Bit 3 is the capture flag, bit 2 is the 8-bit compare B flag, bit 1 is the 8-bit overflow flag and bit 0 is the 8-bit compare A flag.
- R3: When `bus_we` is high, each flag whose `bus_wdata` bit is 1 is cleared. Each flag whose `bus_wdata` bit is 0 keeps its value.
- R4: A high `ack[i]` clears flag bit i at the next clock edge.
- R5: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up 1.
- R6: Set events count only in cycles with `tick` high. A pulse on `t8_oca_evt`, `t8_ov_evt` or `t8_ocb_evt` in such a cycle sets bit 0, 1 or 2 respectively at that clock edge. The same pulse with `tick` low has no effect.
- R7: Take a tick in which `cnt` equals `ocr_a` (or `ocr_b`). Bit 6 (or bit 5) is not set at the edge of that tick. It is set at the edge of the next cycle in which `tick` is high.
- R8: A high `force_a` (or `force_b`) in the tick where `cnt` equals `ocr_a` (or `ocr_b`) means that this match never sets bit 6 (or bit 5).
- R9: Bit 7 sets at the edge of a tick in which `cnt` is all ones, whatever the `mode` value.
- R10: For `mode` values other than 8, 10, 12 and 14, a high `cap_evt` during a tick sets bit 3. For `mode` values 8, 10, 12 and 14 the capture value acts as TOP. In those modes `cap_evt` is ignored, and bit 3 sets at the edge of a tick in which `cnt` equals `icr`.
- R11: `irq[i]` is 1 exactly when flag i is 1, `mask[i]` is 1 and `gie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable; qualifies all set events |
| cnt | input | 16 | 16-bit timer count |
| ocr_a | input | 16 | Compare value A |
| ocr_b | input | 16 | Compare value B |
| icr | input | 16 | Capture value, also TOP in capture-TOP modes |
| mode | input | 4 | Waveform mode select of the 16-bit timer |
| cap_evt | input | 1 | External capture event pulse |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| t8_oca_evt | input | 1 | 8-bit timer compare A pulse |
| t8_ov_evt | input | 1 | 8-bit timer overflow pulse |
| t8_ocb_evt | input | 1 | 8-bit timer compare B pulse |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data; ones clear flags |
| rd_data | output | 8 | Current flag byte |
| ack | input | 8 | Per-flag vector acknowledge pulses |
| mask | input | 8 | Per-flag interrupt enable mask |
| gie | input | 1 | Global interrupt enable |
| irq | output | 8 | Masked interrupt requests |

## Verification
The compare path is tried in three ways: with back-to-back ticks, with idle cycles between the match tick and the next tick, and with a forced strobe that coincides with the match. Together these separate a flag that is set one tick late from one set at equality or one cycle late. Capture is driven by a pin pulse and by the count reaching the capture value, both outside and inside a capture-TOP mode, which shows that the mode switches the source rather than adding one. The clear paths are tried with zero-bit writes, a write to the reserved bit and collisions with set events. These show that only one-bits clear, that the reserved bit stays at 0 and that a set wins over a clear. The request outputs are checked with the mask and the global enable toggled separately.

// File: rtl/tmr_irq_pkg.sv
// Package: flag bit positions and sizes shared by the timer flag register.
// Assumes the bit order is fixed because software decodes it.
package tmr_irq_pkg;
    localparam int NFLAG     = 8;
    localparam int B_T16_OVF = 7;
    localparam int B_T16_CMA = 6;
    localparam int B_T16_CMB = 5;
    localparam int B_RSVD    = 4;
    localparam int B_CAP     = 3;
    localparam int B_T8_CMB  = 2;
    localparam int B_T8_OVF  = 1;
    localparam int B_T8_CMA  = 0;
    localparam logic [NFLAG-1:0] RSVD_MASK = NFLAG'(1) << B_RSVD;
endpackage

// File: rtl/t16_evt.sv
// Module: t16_evt
// Detects the 16-bit timer events and turns them into set pulses.
// Compare matches are recorded in one tick and released in the next tick.
// A forced strobe in the match tick cancels that match. Overflow and
// TOP-reach pulses fire in the tick itself.
// Assumes tick is a one-cycle enable that marks timer steps.
module t16_evt #(
    parameter int CNT_W = 16,
    parameter int NCMP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val [NCMP],
    input  logic [NCMP-1:0]  force_stb,
    input  logic [CNT_W-1:0] icr,
    input  logic             icr_top,
    input  logic             cap_evt,
    output logic [NCMP-1:0]  set_cmp,
    output logic             set_ovf,
    output logic             set_cap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NCMP-1:0] match_q;

    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
        // Record a match (unless forced) on each tick, held until the next tick.
        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q[c] <= 1'b0;
            else if (tick)
                match_q[c] <= (cnt == cmp_val[c]) && !force_stb[c];
        end
        // Release the recorded match as a set pulse on the following tick.
        assign set_cmp[c] = tick && match_q[c];
    end

    // Overflow: count at its maximum during a tick wraps at this edge.
    assign set_ovf = tick && (cnt == CNT_MAX);

    // Capture source: TOP reach in capture-TOP modes, otherwise the pin pulse.
    always_comb begin
        if (icr_top)
            set_cap = tick && (cnt == icr);
        else
            set_cap = tick && cap_evt;
    end
endmodule

// File: rtl/flag_bank.sv
// Module: flag_bank
// Bank of set/clear flags. A set has priority over a same-cycle clear.
// Bits marked reserved are tied to zero.
// Assumes set, write-one clear and acknowledge vectors are bit-aligned.
module flag_bank #(
    parameter int                NFLAG = 8,
    parameter logic [NFLAG-1:0]  RSVD  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        if (RSVD[i]) begin : g_rsvd
            // Reserved position: constant zero.
            assign flags[i] = 1'b0;
        end else begin : g_flag
            // Flag update: set wins, else clear, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else if (set_v[i])
                    flags[i] <= 1'b1;
                else if (clr_v[i])
                    flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Forms masked interrupt requests from flags, the mask and the global enable.
// Purely combinational; assumes the consumer registers the result if needed.
module irq_gate #(
    parameter int NFLAG = 8
) (
    input  logic [NFLAG-1:0] flags,
    input  logic [NFLAG-1:0] mask,
    input  logic             gie,
    output logic [NFLAG-1:0] irq
);
    // Request per flag when flag, mask bit and global enable are all high.
    always_comb begin
        irq = gie ? (flags & mask) : '0;
    end
endmodule

// File: rtl/tmr_irq_flags.sv
// Module: tmr_irq_flags
// Top of the timer interrupt flag register. It gathers the 16-bit event
// pulses and the qualified 8-bit pulses into the flag byte, and it applies
// the write-one and acknowledge clears. It drives the read data and the
// masked requests.
// Assumes modes with mode[3]=1 and mode[0]=0 use the capture value as TOP.
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ocr_a,
    input  logic [CNT_W-1:0] ocr_b,
    input  logic [CNT_W-1:0] icr,
    input  logic [MODE_W-1:0] mode,
    input  logic             cap_evt,
    input  logic             force_a,
    input  logic             force_b,
    input  logic             t8_oca_evt,
    input  logic             t8_ov_evt,
    input  logic             t8_ocb_evt,
    input  logic             bus_we,
    input  logic [NFLAG-1:0] bus_wdata,
    output logic [NFLAG-1:0] rd_data,
    input  logic [NFLAG-1:0] ack,
    input  logic [NFLAG-1:0] mask,
    input  logic             gie,
    output logic [NFLAG-1:0] irq
);
    logic [CNT_W-1:0] cmp_val [2];
    logic [1:0]       set_cmp;
    logic             set_ovf;
    logic             set_cap;
    logic             icr_top;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;

    // Capture-TOP modes: upper mode bit set and lowest mode bit clear.
    assign icr_top    = mode[MODE_W-1] && !mode[0];
    assign cmp_val[0] = ocr_a;
    assign cmp_val[1] = ocr_b;

    t16_evt #(.CNT_W(CNT_W), .NCMP(2)) u_t16 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt      (cnt),
        .cmp_val  (cmp_val),
        .force_stb({force_b, force_a}),
        .icr      (icr),
        .icr_top  (icr_top),
        .cap_evt  (cap_evt),
        .set_cmp  (set_cmp),
        .set_ovf  (set_ovf),
        .set_cap  (set_cap)
    );

    // Set vector in register bit order; 8-bit pulses are qualified by tick.
    always_comb begin
        set_v            = '0;
        set_v[B_T16_OVF] = set_ovf;
        set_v[B_T16_CMA] = set_cmp[0];
        set_v[B_T16_CMB] = set_cmp[1];
        set_v[B_CAP]     = set_cap;
        set_v[B_T8_CMB]  = tick && t8_ocb_evt;
        set_v[B_T8_OVF]  = tick && t8_ov_evt;
        set_v[B_T8_CMA]  = tick && t8_oca_evt;
    end

    // Clear vector: write-one bits and vector acknowledges.
    assign clr_v = (bus_we ? bus_wdata : '0) | ack;

    flag_bank #(.NFLAG(NFLAG), .RSVD(RSVD_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (rd_data)
    );

    irq_gate #(.NFLAG(NFLAG)) u_irq (
        .flags (rd_data),
        .mask  (mask),
        .gie   (gie),
        .irq   (irq)
    );
endmodule

// File: rtl/tmr_irq_flags_chk.sv
// Module: tmr_irq_flags_chk
// Assertion checker bound to tmr_irq_flags; observes its ports only.
module tmr_irq_flags_chk #(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ocr_a,
    input logic [CNT_W-1:0]  ocr_b,
    input logic [CNT_W-1:0]  icr,
    input logic [MODE_W-1:0] mode,
    input logic              cap_evt,
    input logic              force_a,
    input logic              force_b,
    input logic              t8_oca_evt,
    input logic              t8_ov_evt,
    input logic              t8_ocb_evt,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        rd_data,
    input logic [7:0]        ack,
    input logic [7:0]        mask,
    input logic              gie,
    input logic [7:0]        irq
);
    // R2: reserved bit never reads or requests as one.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] && !irq[4]);

    // R6: a flag only rises after a cycle with tick high.
    a_r6_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~$past(rd_data)) != 8'h00) |-> $past(tick));

    // R3: a write-one to bit 0 with no set event clears it.
    a_r3_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[0] && !(tick && t8_oca_evt)) |=> !rd_data[0]);

    // R4: acknowledge of bit 1 with no set event clears it.
    a_r4_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[1] && !(tick && t8_ov_evt)) |=> !rd_data[1]);

    // R5: set wins over a same-cycle clear on bit 2.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && t8_ocb_evt) |=> rd_data[2]);

    // R9: a tick at the all-ones count sets the overflow flag.
    a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == {CNT_W{1'b1}})) |=> rd_data[7]);

    // R11: no request without its flag and mask bit, none without gie.
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~(rd_data & mask)) == 8'h00) && (gie || (irq == 8'h00)));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tmr_irq_flags_tb.sv
// Directed bench for tmr_irq_flags: one task per scenario.
module tmr_irq_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [15:0] cnt, ocr_a, ocr_b, icr;
    logic [3:0]  mode;
    logic        cap_evt, force_a, force_b;
    logic        t8_oca_evt, t8_ov_evt, t8_ocb_evt;
    logic        bus_we;
    logic [7:0]  bus_wdata, rd_data, ack, mask, irq;
    logic        gie;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .ocr_a(ocr_a),
        .ocr_b(ocr_b), .icr(icr), .mode(mode), .cap_evt(cap_evt),
        .force_a(force_a), .force_b(force_b), .t8_oca_evt(t8_oca_evt),
        .t8_ov_evt(t8_ov_evt), .t8_ocb_evt(t8_ocb_evt), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .ack(ack), .mask(mask),
        .gie(gie), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled 1 ns after the edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick = 0; cap_evt = 0; force_a = 0; force_b = 0;
        t8_oca_evt = 0; t8_ov_evt = 0; t8_ocb_evt = 0;
        bus_we = 0; bus_wdata = 8'h00; ack = 8'h00;
        cnt = 16'h0000;
    endtask

    task automatic clear_all();
        idle();
        bus_we = 1; bus_wdata = 8'hFF;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        idle();
        ocr_a = 16'hAAAA; ocr_b = 16'hBBBB; icr = 16'hCCCC; mode = 4'd0;
        mask = 8'hFF; gie = 1;
        rst_n = 0;
        cyc(); cyc();
        check("R1 flags after reset", rd_data, 8'h00);
        check("R1 irq after reset", irq, 8'h00);
        rst_n = 1;
        cyc();
        check("R1 flags stay zero", rd_data, 8'h00);
    endtask

    task automatic t_t8_events();
        t8_oca_evt = 1; tick = 0;
        cyc(); idle();
        check("R6 pulse without tick ignored", rd_data, 8'h00);
        tick = 1; t8_oca_evt = 1;
        cyc(); idle();
        check("R6 8-bit compare A sets bit0", rd_data, 8'h01);
        tick = 1; t8_ov_evt = 1;
        cyc(); idle();
        check("R2 8-bit overflow at bit1", rd_data, 8'h03);
        tick = 1; t8_ocb_evt = 1;
        cyc(); idle();
        check("R2 8-bit compare B at bit2", rd_data, 8'h07);
    endtask

    task automatic t_write_clear();
        bus_we = 1; bus_wdata = 8'h02;
        cyc(); idle();
        check("R3 write-one clears bit1 only", rd_data, 8'h05);
        bus_we = 1; bus_wdata = 8'h00;
        cyc(); idle();
        check("R3 write zero keeps flags", rd_data, 8'h05);
        bus_we = 1; bus_wdata = 8'h10;
        cyc(); idle();
        check("R2 reserved write has no effect", rd_data, 8'h05);
    endtask

    task automatic t_ack_clear();
        ack = 8'h01;
        cyc(); idle();
        check("R4 ack clears bit0", rd_data, 8'h04);
        ack = 8'h04;
        cyc(); idle();
        check("R4 ack clears bit2", rd_data, 8'h00);
    endtask

    task automatic t_set_wins();
        tick = 1; t8_oca_evt = 1; bus_we = 1; bus_wdata = 8'h01;
        cyc(); idle();
        check("R5 set beats write-one clear", rd_data, 8'h01);
        tick = 1; t8_ov_evt = 1; ack = 8'h02;
        cyc(); idle();
        check("R5 set beats acknowledge", rd_data, 8'h03);
        clear_all();
        check("R3 clear all", rd_data, 8'h00);
    endtask

    task automatic t_compare();
        tick = 1; cnt = 16'hAAAA;
        cyc(); idle();
        check("R7 no compare A flag at equality", rd_data, 8'h00);
        cyc(); cyc();
        check("R7 no flag during idle cycles", rd_data, 8'h00);
        tick = 1; cnt = 16'hAAAB;
        cyc(); idle();
        check("R7 compare A flag on next tick", rd_data, 8'h40);
        tick = 1; cnt = 16'hBBBB;
        cyc(); idle();
        tick = 1; cnt = 16'hBBBC;
        cyc(); idle();
        check("R7 compare B flag on next tick", rd_data, 8'h60);
        clear_all();
    endtask

    task automatic t_force();
        tick = 1; cnt = 16'hAAAA; force_a = 1;
        cyc(); idle();
        tick = 1; cnt = 16'h0001;
        cyc(); idle();
        check("R8 forced A match sets nothing", rd_data, 8'h00);
        tick = 1; cnt = 16'hBBBB; force_b = 1;
        cyc(); idle();
        tick = 1; cnt = 16'h0001;
        cyc(); idle();
        check("R8 forced B match sets nothing", rd_data, 8'h00);
    endtask

    task automatic t_overflow();
        mode = 4'd4; tick = 1; cnt = 16'hFFFF;
        cyc(); idle();
        check("R9 overflow sets bit7 at the tick", rd_data, 8'h80);
        mode = 4'd0;
        clear_all();
    endtask

    task automatic t_capture();
        mode = 4'd0; tick = 1; cap_evt = 1;
        cyc(); idle();
        check("R10 pin capture in mode 0", rd_data, 8'h08);
        clear_all();
        mode = 4'd0; tick = 1; cnt = 16'hCCCC;
        cyc(); idle();
        check("R10 count at icr ignored in mode 0", rd_data, 8'h00);
        mode = 4'd12; tick = 1; cap_evt = 1;
        cyc(); idle();
        check("R10 pin ignored in mode 12", rd_data, 8'h00);
        mode = 4'd14; tick = 1; cnt = 16'hCCCC;
        cyc(); idle();
        check("R10 TOP reach sets capture in mode 14", rd_data, 8'h08);
        mode = 4'd0;
        clear_all();
    endtask

    task automatic t_irq();
        tick = 1; t8_oca_evt = 1; t8_ov_evt = 1;
        cyc(); idle();
        mask = 8'h01; gie = 1;
        #1 check("R11 masked request", irq, 8'h01);
        gie = 0;
        #1 check("R11 global enable off", irq, 8'h00);
        gie = 1; mask = 8'h00;
        #1 check("R11 mask off", irq, 8'h00);
        mask = 8'hFF;
        #1 check("R11 all enabled", irq, 8'h03);
        clear_all();
        check("R11 no request when flags clear", irq, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_t8_events();
        t_write_clear();
        t_ack_clear();
        t_set_wins();
        t_compare();
        t_force();
        t_overflow();
        t_capture();
        t_irq();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule